// File: doc/BRIEF.md
# Descriptor Ring Slot Accounting Controller

This block keeps the books for two circular descriptor rings that host software shares with a processing engine. Jobs go into one ring and results come back through the other. Software sets the size of each ring. It then tells the block how many jobs it has placed in the job ring and how many results it has taken from the result ring. The engine reports each job it takes with a consume strobe and each result it writes with a produce strobe.

From these events the block keeps four values: the free room left in the job ring, the number of occupied slots in the result ring, the engine's read position in the job ring and the engine's write position in the result ring. If software claims more than the counters allow, the counters stay as they are and the block posts a coded error. A completion flag and an error flag drive an interrupt, which software can mask. A reset command stops the engine side, waits for the engine to go idle, then clears the counters and positions.

Registers are reached through a small synchronous write port: one write per cycle, selected by a 3-bit address. State can be read directly on dedicated output ports.

Top module: `ring_slot_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following read zero: room, full count, both positions, the status word and irq.
- R2: A write to address 0 sets the job-ring size from data[9:0]. Room becomes that size and the read position becomes 0. A write to address 1 sets the result-ring size the same way. The full count and the write position become 0.
- R3: A write to address 2 adds data[9:0] jobs, and room drops by that amount. If the amount exceeds room, room is unchanged and the status word gets: bit 1 set, error type 9 in bits 11..8, and the read position in bits 29..16.
- R4: A write to address 3 removes data[9:0] results, and the full count drops by that amount. If the amount exceeds the full count, the count is unchanged and the status word gets: bit 1 set, error type 8 in bits 11..8, and the write position in bits 29..16.
- R5: A consume strobe raises room by one and advances the read position modulo the job-ring size. The strobe is ignored when no job is pending, that is, when room equals the size.
- R6: A produce strobe raises the full count by one, advances the write position modulo the result-ring size and sets status bit 0. The strobe is ignored when the result ring is full.
- R7: irq is high exactly when status bit 0 or bit 1 is set and configuration bit 0 (written at address 4) is clear.
- R8: When configuration bit 2 is set and status bit 1 is set, consume and produce strobes are ignored.
- R9: Writing 1 to bit 0 at address 5 starts a halt. While the halt is in progress:
  - status bits 3..2 read 1 until eng_idle is high;
  - engine strobes are ignored;
  - add and remove writes are ignored.
  The halt then completes: bits 3..2 read 2, room returns to the size, and the full count and both positions return to 0.
- R10: A write to address 6 clears status bits by writing 1 to them:
  - data bit 0 clears status bit 0;
  - data bit 1 clears bit 1, the error type and the error index;
  - data bit 3 clears a completed halt, after which bits 3..2 read 0 and the engine side runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| eng_consume | input | 1 | Engine took one job |
| eng_produce | input | 1 | Engine wrote one result |
| eng_idle | input | 1 | Engine has no work in flight |
| in_room | output | 10 | Free slots in the job ring |
| out_full | output | 10 | Occupied slots in the result ring |
| in_rd_idx | output | 10 | Engine read position in the job ring |
| out_wr_idx | output | 10 | Engine write position in the result ring |
| int_status | output | 32 | Status word: flags, halt state, error type, error index |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover four things:
- occupancy never exceeds the ring size;
- a rejected add or remove leaves the counter untouched;
- an accepted produce always raises the completion flag, and nothing is accepted while stop-on-error holds;
- the halt field never reads an illegal value and does not leave the in-progress state before the engine reports idle.

Some behaviour only the bench scenarios can show. These are the exact counter values after sequences of writes, index wraparound at the ring size, the coded error type and index values, and the full reset-command sequence through to write-1-to-clear.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    HALT_NONE = 2'd0,
    HALT_BUSY = 2'd1,
    HALT_DONE = 2'd2
  } halt_e;

  typedef enum logic [2:0] {
    A_IN_SIZE  = 3'd0,
    A_OUT_SIZE = 3'd1,
    A_ADD      = 3'd2,
    A_REMOVE   = 3'd3,
    A_CFG      = 3'd4,
    A_CMD      = 3'd5,
    A_STATUS   = 3'd6
  } reg_addr_e;

  localparam logic [3:0] ERR_REMOVE_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF    = 4'd9;
  localparam int unsigned ERR_IDX_W     = 14;
endpackage

// File: rtl/slot_track.sv
module slot_track #(
  parameter int W        = 10,
  parameter bit SW_FILLS = 1'b1  // 1: software adds occupancy, engine drains it
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         size_we,
  input  logic [W-1:0] size_val,
  input  logic         sw_en,
  input  logic [W-1:0] sw_n,
  input  logic         eng_req,
  input  logic         run,
  input  logic         clr,
  output logic [W-1:0] used_o,
  output logic [W-1:0] free_o,
  output logic [W-1:0] idx_o,
  output logic         sw_ovf,
  output logic         eng_take
);
  logic [W-1:0] size_q, used_q, idx_q;
  logic [W-1:0] up_n, down_n, used_n, idx_n, last_idx;
  logic         eng_ok, sw_ok;

  assign free_o   = size_q - used_q;
  assign used_o   = used_q;
  assign idx_o    = idx_q;
  assign last_idx = size_q - 1'b1;

  generate
    if (SW_FILLS) begin : g_fill
      assign eng_ok = run && eng_req && (used_q != '0);
      assign sw_ovf = sw_en && (sw_n > free_o);
      assign sw_ok  = sw_en && !sw_ovf;
      assign up_n   = sw_ok ? sw_n : '0;
      assign down_n = eng_ok ? W'(1) : '0;
    end else begin : g_drain
      assign eng_ok = run && eng_req && (used_q != size_q);
      assign sw_ovf = sw_en && (sw_n > used_q);
      assign sw_ok  = sw_en && !sw_ovf;
      assign up_n   = eng_ok ? W'(1) : '0;
      assign down_n = sw_ok ? sw_n : '0;
    end
  endgenerate

  assign eng_take = eng_ok;
  assign used_n   = used_q + up_n - down_n;
  assign idx_n    = !eng_ok ? idx_q : ((idx_q == last_idx) ? '0 : idx_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      used_q <= '0;
      idx_q  <= '0;
    end else if (size_we) begin
      size_q <= size_val;
      used_q <= '0;
      idx_q  <= '0;
    end else if (clr) begin
      used_q <= '0;
      idx_q  <= '0;
    end else begin
      used_q <= used_n;
      idx_q  <= idx_n;
    end
  end

  p_used_le_size_r5: assert property (@(posedge clk) disable iff (rst)
    used_q <= size_q);

  // R3 for the job ring, R4 for the result ring
  p_ovf_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_ovf && !eng_ok && !size_we && !clr) |=> (used_q == $past(used_q)));
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       eng_idle,
  input  logic       ack,
  output logic [1:0] halt_code,
  output logic       run,
  output logic       clr
);
  halt_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    clr     = 1'b0;
    unique case (state_q)
      HALT_NONE: if (req) state_n = HALT_BUSY;
      HALT_BUSY: if (eng_idle) begin
        state_n = HALT_DONE;
        clr     = 1'b1;
      end
      HALT_DONE: if (ack) state_n = HALT_NONE;
      default:   state_n = HALT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HALT_NONE;
    else     state_q <= state_n;
  end

  assign halt_code = state_q;
  assign run       = (state_q == HALT_NONE);

  p_halt_legal_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(halt_code));
  p_halt_wait_r9: assert property (@(posedge clk) disable iff (rst)
    (halt_code == 2'd1 && !eng_idle) |=> (halt_code == 2'd1));
endmodule

// File: rtl/ring_slot_ctrl.sv
module ring_slot_ctrl
  import ring_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic         eng_consume,
  input  logic         eng_produce,
  input  logic         eng_idle,
  output logic [W-1:0] in_room,
  output logic [W-1:0] out_full,
  output logic [W-1:0] in_rd_idx,
  output logic [W-1:0] out_wr_idx,
  output logic [31:0]  int_status,
  output logic         irq
);
  localparam int EW = ERR_IDX_W;

  logic         run, clr, eng_run;
  logic [1:0]   halt_code;
  logic         mask_q, soe_q;
  logic         int_q, err_q;
  logic [3:0]   etype_q;
  logic [EW-1:0] eidx_q;
  logic         we_in_size, we_out_size, we_add, we_rm, we_cfg, we_cmd, we_st;
  logic         add_ovf, rm_ovf, cons_take, prod_take;
  logic [W-1:0] in_used_unused, out_free_unused;

  assign we_in_size  = wr_en && (wr_addr == A_IN_SIZE);
  assign we_out_size = wr_en && (wr_addr == A_OUT_SIZE);
  assign we_add      = wr_en && (wr_addr == A_ADD) && run;
  assign we_rm       = wr_en && (wr_addr == A_REMOVE) && run;
  assign we_cfg      = wr_en && (wr_addr == A_CFG);
  assign we_cmd      = wr_en && (wr_addr == A_CMD);
  assign we_st       = wr_en && (wr_addr == A_STATUS);

  assign eng_run = run && !(soe_q && err_q);

  slot_track #(.W(W), .SW_FILLS(1'b1)) u_job (
    .clk(clk), .rst(rst),
    .size_we(we_in_size), .size_val(wr_data[W-1:0]),
    .sw_en(we_add), .sw_n(wr_data[W-1:0]),
    .eng_req(eng_consume), .run(eng_run), .clr(clr),
    .used_o(in_used_unused), .free_o(in_room), .idx_o(in_rd_idx),
    .sw_ovf(add_ovf), .eng_take(cons_take)
  );

  slot_track #(.W(W), .SW_FILLS(1'b0)) u_res (
    .clk(clk), .rst(rst),
    .size_we(we_out_size), .size_val(wr_data[W-1:0]),
    .sw_en(we_rm), .sw_n(wr_data[W-1:0]),
    .eng_req(eng_produce), .run(eng_run), .clr(clr),
    .used_o(out_full), .free_o(out_free_unused), .idx_o(out_wr_idx),
    .sw_ovf(rm_ovf), .eng_take(prod_take)
  );

  halt_fsm u_halt (
    .clk(clk), .rst(rst),
    .req(we_cmd && wr_data[0]),
    .eng_idle(eng_idle),
    .ack(we_st && wr_data[3]),
    .halt_code(halt_code), .run(run), .clr(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b0;
      soe_q   <= 1'b0;
      int_q   <= 1'b0;
      err_q   <= 1'b0;
      etype_q <= '0;
      eidx_q  <= '0;
    end else begin
      if (we_cfg) begin
        mask_q <= wr_data[0];
        soe_q  <= wr_data[2];
      end
      if (prod_take)               int_q <= 1'b1;
      else if (we_st && wr_data[0]) int_q <= 1'b0;
      if (add_ovf) begin
        err_q   <= 1'b1;
        etype_q <= ERR_ADD_OVF;
        eidx_q  <= EW'(in_rd_idx);
      end else if (rm_ovf) begin
        err_q   <= 1'b1;
        etype_q <= ERR_REMOVE_OVF;
        eidx_q  <= EW'(out_wr_idx);
      end else if (we_st && wr_data[1]) begin
        err_q   <= 1'b0;
        etype_q <= '0;
        eidx_q  <= '0;
      end
    end
  end

  assign int_status = {2'b00, eidx_q, 4'b0000, etype_q, 4'b0000, halt_code, err_q, int_q};
  assign irq        = (int_q || err_q) && !mask_q;

  p_produce_flags_r6: assert property (@(posedge clk) disable iff (rst)
    prod_take |=> int_status[0]);
  p_stop_on_err_r8: assert property (@(posedge clk) disable iff (rst)
    (soe_q && err_q) |-> !(cons_take || prod_take));
  p_add_ovf_code_r3: assert property (@(posedge clk) disable iff (rst)
    add_ovf |=> (int_status[11:8] == 4'd9 && int_status[1]));
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !irq);
endmodule

// File: tb/ring_slot_ctrl_test.sv
module ring_slot_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        eng_consume = 1'b0, eng_produce = 1'b0, eng_idle = 1'b0;
  logic [9:0]  in_room, out_full, in_rd_idx, out_wr_idx;
  logic [31:0] int_status;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [9:0] room, full, ri, wi;
    logic [31:0] st;
    logic       irq;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_slot_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_consume(eng_consume), .eng_produce(eng_produce), .eng_idle(eng_idle),
    .in_room(in_room), .out_full(out_full), .in_rd_idx(in_rd_idx),
    .out_wr_idx(out_wr_idx), .int_status(int_status), .irq(irq)
  );

  // monitor: compares the state one step after each posedge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (in_room !== e.room || out_full !== e.full || in_rd_idx !== e.ri ||
          out_wr_idx !== e.wi || int_status !== e.st || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: got room=%0d full=%0d ri=%0d wi=%0d st=%h irq=%b exp room=%0d full=%0d ri=%0d wi=%0d st=%h irq=%b",
                 e.tag, in_room, out_full, in_rd_idx, out_wr_idx, int_status, irq,
                 e.room, e.full, e.ri, e.wi, e.st, e.irq);
      end
    end
  end

  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d,
                       input logic c, input logic p);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; eng_consume = c; eng_produce = p;
  endtask

  task automatic expect_st(input string tag, input int room, input int full,
                           input int ri, input int wi, input logic [31:0] st,
                           input logic irqv);
    exp_t e;
    e.tag = tag; e.room = 10'(room); e.full = 10'(full); e.ri = 10'(ri);
    e.wi = 10'(wi); e.st = st; e.irq = irqv;
    q.push_back(e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got running exp finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    drive(0, 0, 0, 0, 0); expect_st("R1 reset state", 0, 0, 0, 0, 32'h0, 0);
    drive(1, 0, 5, 0, 0); expect_st("R2 job size", 5, 0, 0, 0, 32'h0, 0);
    drive(1, 1, 3, 0, 0); expect_st("R2 result size", 5, 0, 0, 0, 32'h0, 0);
    drive(1, 2, 3, 0, 0); expect_st("R3 add 3", 2, 0, 0, 0, 32'h0, 0);
    drive(1, 2, 3, 0, 0); expect_st("R3 add overflow", 2, 0, 0, 0, 32'h0000_0902, 1);
    drive(1, 6, 2, 0, 0); expect_st("R10 clear error", 2, 0, 0, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 consume 1", 3, 0, 1, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 consume 2", 4, 0, 2, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 consume 3", 5, 0, 3, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 consume empty ignored", 5, 0, 3, 0, 32'h0, 0);
    drive(1, 2, 5, 0, 0); expect_st("R3 add to full", 0, 0, 3, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 consume to last", 1, 0, 4, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R5 read index wrap", 2, 0, 0, 0, 32'h0, 0);
    drive(0, 0, 0, 0, 1); expect_st("R6 produce 1", 2, 1, 0, 1, 32'h1, 1);
    drive(0, 0, 0, 0, 1); expect_st("R6 produce 2", 2, 2, 0, 2, 32'h1, 1);
    drive(0, 0, 0, 0, 1); expect_st("R6 write index wrap", 2, 3, 0, 0, 32'h1, 1);
    drive(0, 0, 0, 0, 1); expect_st("R6 produce full ignored", 2, 3, 0, 0, 32'h1, 1);
    drive(1, 4, 1, 0, 0); expect_st("R7 mask", 2, 3, 0, 0, 32'h1, 0);
    drive(1, 3, 4, 0, 0); expect_st("R4 remove overflow", 2, 3, 0, 0, 32'h0000_0803, 0);
    drive(1, 4, 4, 0, 0); expect_st("R7 unmask with stop", 2, 3, 0, 0, 32'h0000_0803, 1);
    drive(0, 0, 0, 1, 0); expect_st("R8 consume stopped", 2, 3, 0, 0, 32'h0000_0803, 1);
    drive(1, 6, 3, 0, 0); expect_st("R10 clear both", 2, 3, 0, 0, 32'h0, 0);
    drive(1, 3, 2, 0, 0); expect_st("R4 remove 2", 2, 1, 0, 0, 32'h0, 0);
    drive(0, 0, 0, 1, 0); expect_st("R8 consume resumes", 3, 1, 1, 0, 32'h0, 0);
    drive(1, 5, 1, 0, 0); expect_st("R9 halt busy", 3, 1, 1, 0, 32'h4, 0);
    drive(0, 0, 0, 1, 1); expect_st("R9 strobes ignored", 3, 1, 1, 0, 32'h4, 0);
    drive(1, 2, 1, 0, 0); expect_st("R9 add ignored", 3, 1, 1, 0, 32'h4, 0);
    drive(0, 0, 0, 0, 0); eng_idle = 1'b1;
    expect_st("R9 halt done cleared", 5, 0, 0, 0, 32'h8, 0);
    drive(0, 0, 0, 0, 0); expect_st("R9 halt done holds", 5, 0, 0, 0, 32'h8, 0);
    drive(1, 6, 8, 0, 0); expect_st("R10 clear halt", 5, 0, 0, 0, 32'h0, 0);
    drive(0, 0, 0, 0, 1); expect_st("R10 runs again", 5, 1, 0, 1, 32'h1, 1);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule